// File: doc/BRIEF.md
# Cache Test-Mode Request Router

This block sits beside the second-level cache controller and decides what happens to each memory operation. It takes the operation kind, a write-through attribute and the second-level hit status of the operation. From these it produces four routing decisions: allocate a line in the second-level cache, update the second-level data array, send a transaction to the system bus, and issue a global address broadcast. The tag lookup, the arrays and the bus protocol are handled elsewhere. The block only makes the decisions, and it registers them so they are valid one cycle after the request is accepted.

Two configuration bits change the normal policy so that software can fill and inspect the second-level tags and data using only explicit loads and stores. The data-only bit keeps instruction fetches out of the second-level cache, so the first-level instruction cache can stay enabled without disturbing the contents under test. The test-support bit has four effects:
- Flush pushes become second-level allocations.
- Zeroing operations become local.
- Write-through stores stay off the bus.
- A write-through store that misses is dropped, and a sticky flag records the drop.

Top module: `cache_test_router`

## Requirements
- R1: A request accepted on a rising edge (req_valid high) gives out_valid high and its decisions after that edge, held for exactly one cycle. A cycle with no request gives out_valid low and all decision outputs low.
- R2: Operation codes on req_op are LOAD=0, STORE=1, IFETCH=2, FLUSH=3, STORE_FLUSH=4 and ZERO=5. A LOAD that misses sets out_bus and out_alloc. A LOAD that hits sets no decision output.
- R3: With cfg_data_only set, an IFETCH never sets out_alloc. A miss still sets out_bus.
- R4: With cfg_data_only clear, an IFETCH is routed like a LOAD.
- R5: A store with req_wt clear sets out_update on a hit. On a miss it sets out_alloc and out_bus.
- R6: With cfg_test_mode set, FLUSH and STORE_FLUSH set out_alloc and leave out_bus low.
- R7: With cfg_test_mode clear, FLUSH and STORE_FLUSH set out_bus and leave out_alloc low.
- R8: ZERO sets out_bcast when cfg_test_mode is clear, and sets no decision output when cfg_test_mode is set.
- R9: With cfg_test_mode set, a write-through store (req_wt=1) never sets out_bus. On a hit it sets out_update.
- R10: With cfg_test_mode set, a write-through store that misses sets no allocation, pulses out_drop, and sets wt_drop_seen. wt_drop_seen stays high until reset.
- R11: With cfg_test_mode clear, a write-through store sets out_bus, and sets out_update exactly when it hits.
- R12: Codes 6 and 7 give out_valid high with no decision output set.
- R13: While rst_n is low on a rising edge, every output is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_data_only | input | 1 | Keep instruction fetches out of the second-level cache |
| cfg_test_mode | input | 1 | Test-support routing policy |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_wt | input | 1 | Store is write-through |
| req_l2_hit | input | 1 | Second-level lookup hit |
| out_valid | output | 1 | Decisions below are valid |
| out_alloc | output | 1 | Allocate a line in the second-level cache |
| out_update | output | 1 | Write the second-level data array |
| out_bus | output | 1 | Send a transaction to the system bus |
| out_bcast | output | 1 | Global address broadcast |
| out_drop | output | 1 | Write-through store dropped on a miss |
| wt_drop_seen | output | 1 | Sticky record of any drop |

## Verification
The bench builds the block with FILL_ON_MISS at its default of 1. This enables allocation on load, fetch and write-back store misses, so the data-only suppression of fetch allocations can be observed against a fill that would otherwise happen. Random operations, including the reserved codes, are crossed with random hit status, write-through and both configuration bits. This covers every combination of the two test bits. Directed sequences check that the sticky drop flag persists across later normal traffic and that reset clears it.

// File: rtl/ctr_pkg.sv
// Shared types for the cache test-mode request router.
// Assumes a 3-bit operation code; codes 6 and 7 are reserved.
package ctr_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_IFETCH  = 3'd2,
        OP_FLUSH   = 3'd3,
        OP_STFLUSH = 3'd4,
        OP_ZERO    = 3'd5
    } op_e;

    typedef struct packed {
        logic alloc;
        logic update;
        logic bus;
        logic bcast;
        logic drop;
    } route_t;
endpackage

// File: rtl/ctr_decode.sv
// Combinational routing policy. Maps one operation plus its configuration
// bits to a set of decisions. Assumes the hit status belongs to this operation.
module ctr_decode
    import ctr_pkg::*;
#(
    parameter bit FILL_ON_MISS = 1'b1
) (
    input  logic [OP_W-1:0] op,
    input  logic            wt,
    input  logic            l2_hit,
    input  logic            data_only,
    input  logic            test_mode,
    output route_t          route
);
    logic fill;

    // Pick whether misses fill the second-level cache.
    generate
        if (FILL_ON_MISS) begin : g_fill
            assign fill = 1'b1;
        end else begin : g_nofill
            assign fill = 1'b0;
        end
    endgenerate

    // Apply the normal or test-mode routing policy for this operation.
    always_comb begin
        route = '0;
        case (op)
            OP_LOAD: begin
                route.bus   = !l2_hit;
                route.alloc = !l2_hit && fill;
            end
            OP_IFETCH: begin
                route.bus   = !l2_hit;
                route.alloc = !l2_hit && fill && !data_only;
            end
            OP_STORE: begin
                route.update = l2_hit;
                if (wt) begin
                    if (test_mode) route.drop = !l2_hit;
                    else           route.bus  = 1'b1;
                end else begin
                    route.bus   = !l2_hit;
                    route.alloc = !l2_hit && fill;
                end
            end
            OP_FLUSH, OP_STFLUSH: begin
                if (test_mode) route.alloc = 1'b1;
                else           route.bus   = 1'b1;
            end
            OP_ZERO: begin
                route.bcast = !test_mode;
            end
            default: route = '0;
        endcase
    end
endmodule

// File: rtl/ctr_stage.sv
// Output register stage. Holds decisions for one cycle after an accepted
// request and zeroes them on idle cycles. Synchronous active-low reset.
module ctr_stage
    import ctr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  route_t in_route,
    output logic   q_valid,
    output route_t q_route
);
    // Capture the decision of the accepted request, or clear on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_route <= '0;
        end else begin
            q_valid <= in_valid;
            q_route <= in_valid ? in_route : '0;
        end
    end
endmodule

// File: rtl/ctr_sticky.sv
// Sticky flag that records any dropped write-through store since reset.
// Assumes set_pulse is already qualified by request validity.
module ctr_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    output logic flag
);
    // Set on a drop and hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (set_pulse) flag <= 1'b1;
    end

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(flag) |-> flag);
endmodule

// File: rtl/cache_test_router.sv
// Cache test-mode request router. Decides allocate, update, bus-forward and
// broadcast for each operation under the data-only and test-support bits.
// Decisions are registered and appear one cycle after acceptance.
module cache_test_router
    import ctr_pkg::*;
#(
    parameter bit FILL_ON_MISS = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_data_only,
    input  logic            cfg_test_mode,
    input  logic            req_valid,
    input  logic [OP_W-1:0] req_op,
    input  logic            req_wt,
    input  logic            req_l2_hit,
    output logic            out_valid,
    output logic            out_alloc,
    output logic            out_update,
    output logic            out_bus,
    output logic            out_bcast,
    output logic            out_drop,
    output logic            wt_drop_seen
);
    route_t route_d;
    route_t route_q;

    ctr_decode #(.FILL_ON_MISS(FILL_ON_MISS)) u_decode (
        .op        (req_op),
        .wt        (req_wt),
        .l2_hit    (req_l2_hit),
        .data_only (cfg_data_only),
        .test_mode (cfg_test_mode),
        .route     (route_d)
    );

    ctr_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_route (route_d),
        .q_valid  (out_valid),
        .q_route  (route_q)
    );

    ctr_sticky u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (req_valid && route_d.drop),
        .flag      (wt_drop_seen)
    );

    assign out_alloc  = route_q.alloc;
    assign out_update = route_q.update;
    assign out_bus    = route_q.bus;
    assign out_bcast  = route_q.bcast;
    assign out_drop   = route_q.drop;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_alloc || out_update || out_bus || out_bcast || out_drop));

    assert_ifetch_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(req_op) == OP_IFETCH && $past(cfg_data_only)
        |-> !out_alloc);

    assert_flush_to_l2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(cfg_test_mode)
        && ($past(req_op) == OP_FLUSH || $past(req_op) == OP_STFLUSH)
        |-> out_alloc && !out_bus);

    assert_zero_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(req_op) == OP_ZERO && $past(cfg_test_mode)
        |-> !out_bcast);

    assert_wt_no_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(req_op) == OP_STORE && $past(req_wt)
        && $past(cfg_test_mode) |-> !out_bus);

    assert_drop_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> wt_drop_seen && !out_alloc);
endmodule

// File: tb/test_cache_test_router.sv
module test_cache_test_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_data_only = 1'b0;
    logic       cfg_test_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic       req_wt = 1'b0;
    logic       req_l2_hit = 1'b0;
    logic       out_valid, out_alloc, out_update, out_bus, out_bcast, out_drop, wt_drop_seen;

    int checks = 0;
    int failures = 0;
    logic exp_sticky = 1'b0;

    always #10 clk = ~clk;

    cache_test_router i_cache_test_router (
        .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_data_only), .cfg_test_mode(cfg_test_mode),
        .req_valid(req_valid), .req_op(req_op), .req_wt(req_wt), .req_l2_hit(req_l2_hit),
        .out_valid(out_valid), .out_alloc(out_alloc), .out_update(out_update),
        .out_bus(out_bus), .out_bcast(out_bcast), .out_drop(out_drop),
        .wt_drop_seen(wt_drop_seen)
    );

    // Expected decision vector {alloc, update, bus, bcast, drop} from the requirements.
    function automatic logic [4:0] model(input logic [2:0] op, input logic wt, input logic hit,
                                         input logic dm, input logic tm);
        logic a, u, b, c, d;
        {a, u, b, c, d} = 5'b0;
        case (op)
            3'd0: begin b = !hit; a = !hit; end                    // R2
            3'd2: begin b = !hit; a = !hit && !dm; end             // R3, R4
            3'd1: begin
                if (!wt) begin u = hit; a = !hit; b = !hit; end    // R5
                else if (tm) begin u = hit; d = !hit; end          // R9, R10
                else begin u = hit; b = 1'b1; end                  // R11
            end
            3'd3, 3'd4: begin if (tm) a = 1'b1; else b = 1'b1; end // R6, R7
            3'd5: c = !tm;                                         // R8
            default: ;                                             // R12
        endcase
        return {a, u, b, c, d};
    endfunction

    function automatic string tag(input logic [2:0] op, input logic wt, input logic tm, input logic dm);
        case (op)
            3'd0: return "R2";
            3'd2: return dm ? "R3" : "R4";
            3'd1: return !wt ? "R5" : (tm ? "R9/R10" : "R11");
            3'd3, 3'd4: return tm ? "R6" : "R7";
            3'd5: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check the outputs one cycle later.
    task automatic send(input logic [2:0] op, input logic wt, input logic hit,
                        input logic dm, input logic tm);
        logic [4:0] e;
        req_valid = 1'b1; req_op = op; req_wt = wt; req_l2_hit = hit;
        cfg_data_only = dm; cfg_test_mode = tm;
        e = model(op, wt, hit, dm, tm);
        if (e[0]) exp_sticky = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag(op, wt, tm, dm),
              {out_valid, out_alloc, out_update, out_bus, out_bcast, out_drop, wt_drop_seen},
              {1'b1, e, exp_sticky});
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R1", {out_valid, out_alloc, out_update, out_bus, out_bcast, out_drop, wt_drop_seen},
              {6'b0, exp_sticky});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        req_valid = 1'b1; req_op = 3'd1; req_wt = 1'b1; cfg_test_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R13: reset clears everything even with a request present
        check("R13", {out_valid, out_alloc, out_update, out_bus, out_bcast, out_drop, wt_drop_seen}, 7'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        idle_check();
        // directed corners
        send(3'd0, 0, 0, 0, 0);   // R2 load miss
        send(3'd0, 0, 1, 0, 0);   // R2 load hit
        send(3'd2, 0, 0, 1, 0);   // R3 fetch miss data-only
        send(3'd2, 0, 0, 0, 0);   // R4
        send(3'd1, 0, 1, 0, 1);   // R5
        send(3'd3, 0, 0, 0, 1);   // R6
        send(3'd4, 0, 1, 0, 1);   // R6
        send(3'd3, 0, 0, 0, 0);   // R7
        send(3'd5, 0, 0, 0, 0);   // R8
        send(3'd5, 0, 0, 0, 1);   // R8
        send(3'd1, 1, 1, 0, 1);   // R9
        send(3'd1, 1, 0, 0, 0);   // R11
        send(3'd6, 0, 0, 1, 1);   // R12
        send(3'd7, 1, 0, 0, 0);   // R12
        idle_check();             // R1 single-cycle hold
        send(3'd1, 1, 0, 0, 1);   // R10 drop
        send(3'd0, 0, 0, 0, 0);   // R10 flag persists
        idle_check();
        // random traffic
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0) idle_check();
            else send(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        // R13: reset clears the sticky flag
        @(negedge clk); rst_n = 1'b0; exp_sticky = 1'b0;
        @(negedge clk);
        check("R13", {out_valid, out_alloc, out_update, out_bus, out_bcast, out_drop, wt_drop_seen}, 7'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule